// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide programming front end of an eight-line prioritised interrupt controller. Software reaches it through two addresses. It turns writes into an initialisation sequence of up to four words, into end-of-interrupt, rotation and priority commands, and into commands that pick the register read back, arm a poll or switch the special mask mode. Outside initialisation, writes to the second address load the line mask.

The block owns the vector base, the auto end-of-interrupt mode, the rotate-on-auto-end mode, the nested mode flag, the rotation offset and the in-service register. The request latch and the priority resolver sit outside it. The latch supplies the pending vector. The resolver supplies the winning line and a valid flag, which it computes from the mask, in-service and offset values this block drives out. Each interrupt acknowledge is a one-cycle `inta` pulse. On that same cycle the block returns the vector as base plus line, and it updates its in-service and offset state on the following clock edge.

Top module: `irqc_cmd_seq`

## Requirements
- R1: After reset the mask, in-service register, rotation offset, special-mask flag and nested flag are all zero. A read of address 0 returns `pend_i`.
- R2: A write to address 0 with data bit 4 set clears the mask, in-service, offset, vector base, read select, poll, special mask, auto-end, rotate-on-auto-end and nested state. It also starts the initialisation sequence, which records data bit 0 as "mode word follows" and data bit 1 as "single controller".
- R3: The first address-1 write after the start stores the vector base as data AND 0xF8. The sequence then expects the mode word if single and mode word follows. It ends if single without a mode word. Otherwise it expects the cascade word. Address-1 writes inside the sequence leave the mask unchanged.
- R4: The cascade word is discarded. The sequence then expects the mode word if one follows, and otherwise it ends. In the mode word, bit 4 sets the nested flag and bit 1 sets auto-end mode, and the sequence ends.
- R5: Outside initialisation, an address-1 write loads the mask. An address-1 read (with no poll armed) returns the mask.
- R6: A write to address 0 with data bits 4:3 = 01 is an operation command. Bit 2 arms a poll. Bit 1 set copies bit 0 into the read select, where 1 selects in-service and 0 selects pending for address-0 reads. Bit 6 set copies bit 5 into the special-mask flag; with bit 6 clear that flag is unchanged.
- R7: On an address-0 write with bits 4:3 = 00, data[7:5] is a command. Commands 0 and 4 set rotate-on-auto-end to 0 and 1 respectively. Command 2 changes nothing.
- R8: Command 1 clears the in-service bit of highest priority. Priority order starts at the line equal to the offset and ascends modulo 8. Command 5 does the same and also sets the offset to that line + 1 mod 8. Neither has any effect when no bit is in service.
- R9: Command 3 clears in-service bit data[2:0]. Command 6 sets the offset to data[2:0] + 1 mod 8. Command 7 clears in-service bit data[2:0] and sets the offset to data[2:0] + 1 mod 8.
- R10: When `inta` is high with `req_valid`, `vector` equals base + `req_line` in the same cycle, and `ack_o` pulses with `ack_line_o` = `req_line`. Outside auto-end mode the line's in-service bit is set at the next edge.
- R11: In auto-end mode an acknowledge leaves the in-service register unchanged. If rotate-on-auto-end is enabled, the offset becomes line + 1 mod 8.
- R12: When `inta` is high without `req_valid`, `vector` equals base + 7, no acknowledge is issued and no state changes.
- R13: A read while a poll is armed returns 0x80 OR `req_line` and acknowledges that line as in R10/R11 if `req_valid`. Otherwise it returns 0x00. Every read clears the poll flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| inta | input | 1 | One-cycle interrupt acknowledge |
| vector | output | 8 | Vector returned in the `inta` cycle |
| pend_i | input | 8 | Pending vector from the request latch |
| req_valid | input | 1 | Resolver has a winning line |
| req_line | input | 3 | Winning line from the resolver |
| mask_o | output | 8 | Line mask |
| insvc_o | output | 8 | In-service register |
| rot_off_o | output | 3 | Rotation offset (lowest-priority boundary) |
| special_mask_o | output | 1 | Special-mask mode flag |
| nested_o | output | 1 | Special nested mode flag |
| ack_o | output | 1 | Acknowledge pulse to the request latch |
| ack_line_o | output | 3 | Line being acknowledged |

## Verification
The hardest state to reach is the rotated, partly filled in-service register that a non-specific end-of-interrupt has to search. It needs an earlier rotation command, several acknowledges outside auto-end mode and then the command itself, all with no reinitialisation in between. The stimulus builds that state with directed sequences first: rotate, acknowledge three lines that straddle the offset, then issue non-specific and rotating ends. After that, long random runs of acknowledges and priority commands follow. A random address-0 write seldom reaches initialisation, because the random data is biased away from bit 4. The auto-end paths get a directed init sequence that ends with a mode word.

// File: rtl/irqc_pkg.sv
// Package: shared constants and types for the interrupt command sequencer.
// Assumes eight request lines and byte-wide bus data, fixed by the command encoding.
package irqc_pkg;
    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);
    localparam int DW    = 8;

    // Position within the initialisation word sequence.
    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_BASE = 2'd1,
        STEP_CASC = 2'd2,
        STEP_MODE = 2'd3
    } init_step_e;

    // Priority command codes carried in data[7:5].
    typedef enum logic [2:0] {
        PC_ROT_AE_OFF = 3'd0,
        PC_EOI_HI     = 3'd1,
        PC_NOP        = 3'd2,
        PC_EOI_LINE   = 3'd3,
        PC_ROT_AE_ON  = 3'd4,
        PC_EOI_HI_ROT = 3'd5,
        PC_SET_LOW    = 3'd6,
        PC_EOI_ROT    = 3'd7
    } pri_cmd_e;

    // One-hot classification of a bus write.
    typedef struct packed {
        logic init_start;
        logic op_cmd;
        logic pri_cmd;
        logic port1_wr;
    } wr_class_t;
endpackage

// File: rtl/irqc_wr_decode.sv
// Module: classifies a bus write by address and data bits 4:3.
// Assumes at most one write per cycle; purely combinational.
module irqc_wr_decode
    import irqc_pkg::*;
(
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output wr_class_t     cls
);
    // Decode the write into exactly one class (or none).
    always_comb begin
        cls            = '0;
        cls.init_start = wr_en && !addr && wdata[4];
        cls.op_cmd     = wr_en && !addr && !wdata[4] && wdata[3];
        cls.pri_cmd    = wr_en && !addr && !wdata[4] && !wdata[3];
        cls.port1_wr   = wr_en && addr;
    end
endmodule

// File: rtl/irqc_init_seq.sv
// Module: walks the multi-word initialisation sequence and holds the
// configuration it sets (vector base, nested flag, auto-end mode).
// Assumes address-1 writes reach it only through cls.port1_wr.
module irqc_init_seq
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  wr_class_t     cls,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic [DW-1:0] base,
    output logic          nested,
    output logic          auto_end
);
    localparam logic [DW-1:0] BASE_MASK = DW'(8'hF8);

    init_step_e step;
    logic       mode_follows;
    logic       single;

    // Sequence state and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step         <= STEP_IDLE;
            mode_follows <= 1'b0;
            single       <= 1'b0;
            base         <= '0;
            nested       <= 1'b0;
            auto_end     <= 1'b0;
        end else if (cls.init_start) begin
            step         <= STEP_BASE;
            mode_follows <= wdata[0];
            single       <= wdata[1];
            base         <= '0;
            nested       <= 1'b0;
            auto_end     <= 1'b0;
        end else if (cls.port1_wr) begin
            unique case (step)
                STEP_BASE: begin
                    base <= wdata & BASE_MASK;
                    if (single) step <= mode_follows ? STEP_MODE : STEP_IDLE;
                    else        step <= STEP_CASC;
                end
                STEP_CASC: step <= mode_follows ? STEP_MODE : STEP_IDLE;
                STEP_MODE: begin
                    nested   <= wdata[4];
                    auto_end <= wdata[1];
                    step     <= STEP_IDLE;
                end
                default: ;
            endcase
        end
    end

    // Address-1 writes belong to the sequence while it is not idle.
    assign busy = (step != STEP_IDLE);
endmodule

// File: rtl/irqc_svc_state.sv
// Module: in-service register, rotation offset and rotate-on-auto-end flag.
// Applies acknowledges and priority commands; a restart of initialisation
// overrides both. Assumes ack and command rarely coincide; if they do, both
// in-service updates apply and the command's offset wins.
module irqc_svc_state
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wr_class_t        cls,
    input  logic [DW-1:0]    wdata,
    input  logic             ack,
    input  logic [LW-1:0]    ack_line,
    input  logic             auto_end,
    output logic [LINES-1:0] insvc,
    output logic [LW-1:0]    offset,
    output logic             rot_ae
);
    logic             hi_valid;
    logic [LW-1:0]    hi_line;
    logic [LINES-1:0] insvc_n;
    logic [LW-1:0]    offset_n;
    logic             rot_ae_n;
    pri_cmd_e         cmd;
    logic [LW-1:0]    dline;

    assign cmd   = pri_cmd_e'(wdata[7:5]);
    assign dline = wdata[LW-1:0];

    // Highest-priority in-service line, counting up from the offset.
    always_comb begin
        hi_valid = 1'b0;
        hi_line  = '0;
        for (int p = LINES - 1; p >= 0; p--) begin
            logic [LW-1:0] ln;
            ln = offset + LW'(p);
            if (insvc[ln]) begin
                hi_valid = 1'b1;
                hi_line  = ln;
            end
        end
    end

    // Next-state for in-service bits, offset and rotate flag.
    always_comb begin
        insvc_n  = insvc;
        offset_n = offset;
        rot_ae_n = rot_ae;
        if (ack) begin
            if (!auto_end)   insvc_n[ack_line] = 1'b1;
            else if (rot_ae) offset_n = ack_line + LW'(1);
        end
        if (cls.pri_cmd) begin
            unique case (cmd)
                PC_ROT_AE_OFF: rot_ae_n = 1'b0;
                PC_ROT_AE_ON:  rot_ae_n = 1'b1;
                PC_EOI_HI, PC_EOI_HI_ROT: begin
                    if (hi_valid) begin
                        insvc_n[hi_line] = 1'b0;
                        if (cmd == PC_EOI_HI_ROT) offset_n = hi_line + LW'(1);
                    end
                end
                PC_EOI_LINE: insvc_n[dline] = 1'b0;
                PC_SET_LOW:  offset_n = dline + LW'(1);
                PC_EOI_ROT: begin
                    insvc_n[dline] = 1'b0;
                    offset_n       = dline + LW'(1);
                end
                default: ;
            endcase
        end
        if (cls.init_start) begin
            insvc_n  = '0;
            offset_n = '0;
            rot_ae_n = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insvc  <= '0;
            offset <= '0;
            rot_ae <= 1'b0;
        end else begin
            insvc  <= insvc_n;
            offset <= offset_n;
            rot_ae <= rot_ae_n;
        end
    end
endmodule

// File: rtl/irqc_op_regs.sv
// Module: mask, read select, special-mask flag and poll flag.
// Assumes mask loads only when the init sequence is idle.
module irqc_op_regs
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wr_class_t        cls,
    input  logic [DW-1:0]    wdata,
    input  logic             init_busy,
    input  logic             rd_en,
    output logic [LINES-1:0] mask,
    output logic             rd_sel_svc,
    output logic             spec_mask,
    output logic             poll
);
    // Operation registers; a read clears poll unless the same cycle re-arms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask       <= '0;
            rd_sel_svc <= 1'b0;
            spec_mask  <= 1'b0;
            poll       <= 1'b0;
        end else if (cls.init_start) begin
            mask       <= '0;
            rd_sel_svc <= 1'b0;
            spec_mask  <= 1'b0;
            poll       <= 1'b0;
        end else begin
            if (rd_en) poll <= 1'b0;
            if (cls.port1_wr && !init_busy) mask <= wdata[LINES-1:0];
            if (cls.op_cmd) begin
                if (wdata[2]) poll       <= 1'b1;
                if (wdata[1]) rd_sel_svc <= wdata[0];
                if (wdata[6]) spec_mask  <= wdata[5];
            end
        end
    end
endmodule

// File: rtl/irqc_cmd_seq.sv
// Module: top of the command sequencer. Ties the decoder, init sequence,
// service state and operation registers together, and forms the read data,
// the acknowledge vector and the acknowledge pulse.
// Assumes the external resolver drives req_valid/req_line from the outputs.
module irqc_cmd_seq
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic             inta,
    output logic [DW-1:0]    vector,
    input  logic [LINES-1:0] pend_i,
    input  logic             req_valid,
    input  logic [LW-1:0]    req_line,
    output logic [LINES-1:0] mask_o,
    output logic [LINES-1:0] insvc_o,
    output logic [LW-1:0]    rot_off_o,
    output logic             special_mask_o,
    output logic             nested_o,
    output logic             ack_o,
    output logic [LW-1:0]    ack_line_o
);
    localparam logic [LW-1:0] SPURIOUS_LINE = LW'(LINES - 1);

    wr_class_t     cls;
    logic          init_busy;
    logic [DW-1:0] base;
    logic          auto_end;
    logic          rot_ae;
    logic          rd_sel_svc;
    logic          poll;
    logic          ack;

    irqc_wr_decode u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cls   (cls)
    );

    irqc_init_seq u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (cls),
        .wdata    (wdata),
        .busy     (init_busy),
        .base     (base),
        .nested   (nested_o),
        .auto_end (auto_end)
    );

    irqc_svc_state u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (cls),
        .wdata    (wdata),
        .ack      (ack),
        .ack_line (req_line),
        .auto_end (auto_end),
        .insvc    (insvc_o),
        .offset   (rot_off_o),
        .rot_ae   (rot_ae)
    );

    irqc_op_regs u_ops (
        .clk        (clk),
        .rst_n      (rst_n),
        .cls        (cls),
        .wdata      (wdata),
        .init_busy  (init_busy),
        .rd_en      (rd_en),
        .mask       (mask_o),
        .rd_sel_svc (rd_sel_svc),
        .spec_mask  (special_mask_o),
        .poll       (poll)
    );

    // Acknowledge comes from an inta pulse or a polled read with a winner.
    assign ack        = req_valid && (inta || (rd_en && poll));
    assign ack_o      = ack;
    assign ack_line_o = req_line;

    // Vector: aligned base with the winning or the spurious line in the low bits.
    assign vector = {base[DW-1:LW], req_valid ? req_line : SPURIOUS_LINE};

    // Read data: poll result first, then register select by address.
    always_comb begin
        if (poll)            rdata = req_valid ? {1'b1, {(DW-LW-1){1'b0}}, req_line} : '0;
        else if (addr)       rdata = mask_o;
        else if (rd_sel_svc) rdata = insvc_o;
        else                 rdata = pend_i;
    end
endmodule

// File: rtl/irqc_cmd_seq_sva.sv
// Checker: port-level properties of the command sequencer, bound to the top.
module irqc_cmd_seq_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic       inta,
    input logic       req_valid,
    input logic [2:0] req_line,
    input logic [7:0] mask_o,
    input logic [7:0] insvc_o,
    input logic [2:0] rot_off_o,
    input logic       special_mask_o,
    input logic       nested_o,
    input logic       ack_o,
    input logic [2:0] ack_line_o
);
    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (insvc_o == 8'h00 && mask_o == 8'h00 &&
                                          rot_off_o == 3'd0 && !special_mask_o && !nested_o));

    a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_o));

    a_r6_special_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4:3] == 2'b01 && !wdata[6]) |=> $stable(special_mask_o));

    a_r8_end_sets_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4:3] == 2'b00 && !inta && !rd_en)
            |=> ((insvc_o & ~$past(insvc_o)) == 8'h00));

    a_r10_ack_on_inta: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && req_valid) |-> (ack_o && ack_line_o == req_line));

    a_r12_spurious_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !req_valid && !rd_en) |-> !ack_o);
endmodule

bind irqc_cmd_seq irqc_cmd_seq_sva u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .addr           (addr),
    .wdata          (wdata),
    .inta           (inta),
    .req_valid      (req_valid),
    .req_line       (req_line),
    .mask_o         (mask_o),
    .insvc_o        (insvc_o),
    .rot_off_o      (rot_off_o),
    .special_mask_o (special_mask_o),
    .nested_o       (nested_o),
    .ack_o          (ack_o),
    .ack_line_o     (ack_line_o)
);

// File: tb/irqc_cmd_seq_bench.sv
// Bench: directed corner cases plus seeded random operations, checked
// against a requirement-level model held in bench variables.
module irqc_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, vector, pend_i = '0, mask_o, insvc_o;
    logic       req_valid = 1'b0;
    logic [2:0] req_line = '0, rot_off_o, ack_line_o;
    logic       special_mask_o, nested_o, ack_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Model state.
    logic [7:0] m_mask, m_svc, m_base;
    logic [2:0] m_off;
    logic [1:0] m_step;
    bit m_rot, m_ae, m_nest, m_four, m_single, m_rsel, m_sm, m_poll;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_cmd_seq u_irqc_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .inta(inta), .vector(vector),
        .pend_i(pend_i), .req_valid(req_valid), .req_line(req_line),
        .mask_o(mask_o), .insvc_o(insvc_o), .rot_off_o(rot_off_o),
        .special_mask_o(special_mask_o), .nested_o(nested_o),
        .ack_o(ack_o), .ack_line_o(ack_line_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic m_clear();
        m_mask = 0; m_svc = 0; m_base = 0; m_off = 0; m_step = 0;
        m_rot = 0; m_ae = 0; m_nest = 0; m_four = 0; m_single = 0;
        m_rsel = 0; m_sm = 0; m_poll = 0;
    endtask

    function automatic int hi_line();
        for (int p = 0; p < 8; p++) begin
            int ln = (p + m_off) % 8;
            if (m_svc[ln]) return ln;
        end
        return -1;
    endfunction

    task automatic m_ack(input logic [2:0] ln);
        if (!m_ae) m_svc[ln] = 1'b1;
        else if (m_rot) m_off = ln + 3'd1;
    endtask

    task automatic m_write(input bit a, input logic [7:0] d);
        if (!a && d[4]) begin
            m_clear(); m_step = 1; m_four = d[0]; m_single = d[1];
        end else if (!a && d[3]) begin
            if (d[2]) m_poll = 1;
            if (d[1]) m_rsel = d[0];
            if (d[6]) m_sm = d[5];
        end else if (!a) begin
            int h = hi_line();
            case (d[7:5])
                3'd0, 3'd4: m_rot = d[7];
                3'd1, 3'd5: if (h >= 0) begin
                    m_svc[h] = 1'b0;
                    if (d[7:5] == 3'd5) m_off = 3'(h + 1);
                end
                3'd3: m_svc[d[2:0]] = 1'b0;
                3'd6: m_off = d[2:0] + 3'd1;
                3'd7: begin m_svc[d[2:0]] = 1'b0; m_off = d[2:0] + 3'd1; end
                default: ;
            endcase
        end else begin
            case (m_step)
                2'd0: m_mask = d;
                2'd1: begin
                    m_base = d & 8'hF8;
                    m_step = m_single ? (m_four ? 2'd3 : 2'd0) : 2'd2;
                end
                2'd2: m_step = m_four ? 2'd3 : 2'd0;
                default: begin m_nest = d[4]; m_ae = d[1]; m_step = 0; end
            endcase
        end
    endtask

    // One bus/ack operation: drive at negedge, check same-cycle outputs,
    // update the model, then check registered state after the edge.
    task automatic op(input bit w, input bit r, input bit ia, input bit a,
                      input logic [7:0] d, input bit rv, input logic [2:0] rl,
                      input string tag);
        logic [7:0] exp_rd;
        @(negedge clk);
        wr_en = w; rd_en = r; inta = ia; addr = a; wdata = d;
        req_valid = rv; req_line = rl; pend_i = 8'($urandom);
        #1;
        if (r) begin
            if (m_poll) exp_rd = rv ? (8'h80 | {5'd0, rl}) : 8'h00;
            else if (a) exp_rd = m_mask;
            else exp_rd = m_rsel ? m_svc : pend_i;
            check({tag, " rdata"}, rdata, exp_rd);
        end
        if (ia) begin
            check({tag, " vector"}, vector, m_base + (rv ? rl : 8'd7));
            check({tag, " ack"}, {ack_o, ack_line_o}, {rv, rl});
        end
        if (w) m_write(a, d);
        if (r) begin
            if (m_poll && rv) m_ack(rl);
            m_poll = 0;
        end
        if (ia && rv) m_ack(rl);
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; inta = 0;
        check({tag, " mask"}, mask_o, m_mask);
        check({tag, " insvc"}, insvc_o, m_svc);
        check({tag, " offset"}, rot_off_o, m_off);
        check({tag, " flags"}, {special_mask_o, nested_o}, {m_sm, m_nest});
    endtask

    task automatic wr(input bit a, input logic [7:0] d, input string tag);
        op(1, 0, 0, a, d, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state and pending read
        op(0, 1, 0, 0, 0, 0, 0, "R1 reset read");

        // R2 R3 R4: cascaded init with mode word, auto-end off, nested on
        wr(0, 8'h11, "R2 start");
        wr(1, 8'h00, "R5 mask write ignored"); // consumed as R3 base (0)
        wr(0, 8'h11, "R2 restart");
        wr(1, 8'h47, "R3 base");
        wr(1, 8'h04, "R4 cascade");
        wr(1, 8'h10, "R4 mode nested");
        wr(1, 8'hA5, "R5 mask load");
        op(0, 1, 0, 1, 0, 0, 0, "R5 mask read");
        wr(1, 8'h00, "R5 mask clear");
        // R3: single without mode word ends after base
        wr(0, 8'h12, "R3 single start");
        wr(1, 8'h20, "R3 single base");
        wr(1, 8'h3C, "R3 mask after single");
        wr(1, 8'h00, "R5 mask clear2");

        // R10: acknowledges fill in-service; R6 read select
        op(0, 0, 1, 0, 0, 1, 3'd6, "R10 ack6");
        op(0, 0, 1, 0, 0, 1, 3'd1, "R10 ack1");
        op(0, 0, 1, 0, 0, 1, 3'd3, "R10 ack3");
        op(0, 0, 1, 0, 0, 0, 3'd2, "R12 spurious");
        wr(0, 8'h0B, "R6 select in-service");
        op(0, 1, 0, 0, 0, 0, 0, "R6 read in-service");
        wr(0, 8'h68, "R6 special mask on");
        wr(0, 8'h08, "R6 special mask hold");
        // R9 R8: rotate offset so search wraps
        wr(0, 8'hC4, "R9 set low 4");           // offset 5: order 5,6,7,0,1,..
        wr(0, 8'h20, "R8 nonspecific");         // clears 6
        wr(0, 8'hA0, "R8 rotating nonspecific");// clears 1, offset 2
        wr(0, 8'h40, "R7 nop");
        wr(0, 8'h63, "R9 specific");            // clears 3
        wr(0, 8'h20, "R8 empty");
        op(0, 0, 1, 0, 0, 1, 3'd0, "R10 ack0");
        wr(0, 8'hE0, "R9 rotating specific");

        // R13: poll with and without winner
        wr(0, 8'h0C, "R13 arm poll");
        op(0, 1, 0, 1, 0, 1, 3'd5, "R13 poll hit");
        op(0, 1, 0, 0, 0, 1, 3'd2, "R13 poll cleared");
        wr(0, 8'h0C, "R13 arm poll2");
        op(0, 1, 0, 0, 0, 0, 3'd4, "R13 poll none");

        // R11: auto-end with rotation
        wr(0, 8'h13, "R2 single mode start");
        wr(1, 8'h88, "R3 base single");
        wr(1, 8'h02, "R4 mode auto-end");
        wr(0, 8'h80, "R7 rotate on");
        op(0, 0, 1, 0, 0, 1, 3'd4, "R11 ack rotate");
        wr(0, 8'h00, "R7 rotate off");
        op(0, 0, 1, 0, 0, 1, 3'd2, "R11 ack no rotate");

        // Random mix.
        for (int i = 0; i < 1500; i++) begin
            int k = $urandom % 8;
            logic [7:0] d = 8'($urandom);
            bit rv = 1'($urandom);
            logic [2:0] rl = 3'($urandom);
            case (k)
                0: wr(0, ($urandom % 16 == 0) ? (d | 8'h10) : (d & 8'hEF), "R2 R7 random write0");
                1: wr(1, d, "R3 R5 random write1");
                2: op(0, 1, 0, 0, 0, rv, rl, "R6 R13 random read0");
                3: op(0, 1, 0, 1, 0, rv, rl, "R5 R13 random read1");
                4, 5: op(0, 0, 1, 0, 0, rv, rl, "R10 R11 R12 random ack");
                6: wr(0, (d & 8'hE7) | 8'h08, "R6 random op");
                default: wr(0, d & 8'hE7, "R8 R9 random pri");
            endcase
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule